// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block sequences self-programming of a small on-chip program memory. A CPU writes command bits into an 8-bit control register. A command only takes effect if the matching store or load strobe follows within a short arming window. Store strobes carry a word pointer and a data word. With only the enable bit armed, a store deposits one word into a temporary page buffer. With an erase or page-write command armed, a store starts a timed operation on the page that the pointer's upper bits select. With a configuration-read command armed, a load returns a fuse or lock byte instead of a program word.

Erase and page write are timed by a cycle counter whose length comes from an oscillator frequency and an operation time in microseconds. The default is 4000 us, inside the 3.7 ms to 4.5 ms band. While an operation runs, `busy` is high. Register writes, stores and loads are ignored until it ends. Once an operation has started, an assertion of reset does not stop it. The memory is updated at the cycle the operation ends, and the buffer contents are kept through reset until then.

Top module: `fsp_ctrl`

## Requirements
- R1: While reset is held, and after its release with no operation running, `reg_rdata` reads 0x00, `busy` is 0 and `ld_valid` is 0.
- R2: Bits 7..4 of `reg_rdata` always read zero. Bit 4 (buffer clear) acts on the write and does not read back.
- R3: A register write with bit 0 (enable) set arms exactly one command, in priority order: bit 1 erase, then bit 2 page write, then bit 3 configuration read, else buffer fill. The readback shows bit 0 plus the chosen command bit. A write with bit 0 clear arms nothing.
- R4: A store is accepted only on one of the 4 clock edges after the arming write (fill, erase, page write). A configuration load is accepted only on one of the 3 edges after it. After the last edge of the window, the armed bits read zero, and a later request has no effect.
- R5: An accepted fill store writes `st_data` into buffer word `ptr[OFF_W-1:0]` and clears the enable bit.
- R6: A register write with bit 4 set returns every buffer word to all ones, discarding loaded data.
- R7: Page erase sets every word of page `ptr[PTR_W-1:OFF_W]` to all ones. Page write replaces that page with the buffer contents, after which the buffer returns to all ones.
- R8: `busy` rises on the edge that accepts the erase or write store and stays high for exactly OP_CYCLES cycles. Meanwhile the readback shows enable plus the running command bit. The memory change is visible once `busy` falls.
- R9: While `busy` is high, register writes, stores and loads have no effect, and `ld_valid` stays 0.
- R10: An accepted configuration load returns FUSE_VAL when `ptr[0]` is 0 and LOCK_VAL when it is 1, zero-extended. It also clears the armed bits.
- R11: Any other load outside `busy` gives `ld_valid` one cycle later, with the program word at `ptr`.
- R12: If reset is asserted while an operation runs, `busy` stays high to the operation's normal end, and the memory is updated as without reset.
- R13: When a request is accepted in the same cycle as a register write, the request takes effect and the register write, including its buffer-clear bit, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (does not abort a running operation) |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| st_req | input | 1 | Store request strobe |
| ld_req | input | 1 | Load request strobe |
| ptr | input | PTR_W | Word pointer: page in upper bits, word offset in lower OFF_W bits |
| st_data | input | WORD_W | Data word for a fill store |
| ld_valid | output | 1 | Load result valid, one cycle after an accepted load |
| ld_data | output | WORD_W | Load result |
| busy | output | 1 | Timed erase or write in progress |

## Verification
Two functions can fall in the same cycle: acceptance of a fill store inside its window, and a register write that carries the buffer-clear bit. The bench drives both strobes on one edge while a fill is armed. It then commits the buffer with a page write and reads the page back. The stored word must be present and the readback must show nothing armed. Window boundaries are provoked the same way, by placing a request on the last accepted edge and on the first edge after it.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

   localparam int unsigned CB_EN     = 0;
   localparam int unsigned CB_ERASE  = 1;
   localparam int unsigned CB_WPROG  = 2;
   localparam int unsigned CB_CFGRD  = 3;
   localparam int unsigned CB_BUFCLR = 4;

   typedef enum logic [2:0] {
      ARM_IDLE,
      ARM_FILL,
      ARM_ERASE,
      ARM_WPROG,
      ARM_CFGRD
   } arm_e;

   function automatic arm_e decode_cmd(input logic [3:0] v);
      if (!v[CB_EN])         return ARM_IDLE;
      else if (v[CB_ERASE])  return ARM_ERASE;
      else if (v[CB_WPROG])  return ARM_WPROG;
      else if (v[CB_CFGRD])  return ARM_CFGRD;
      else                   return ARM_FILL;
   endfunction

endpackage

// File: rtl/fsp_arm.sv
module fsp_arm
   import fsp_pkg::*;
#(
   parameter int unsigned WIN_ST = 4,
   parameter int unsigned WIN_LD = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy_i,
   input  logic       done_i,
   input  logic       wr_i,
   input  logic [3:0] cmd_i,
   input  logic       take_i,
   input  logic       start_i,
   output arm_e       kind_o,
   output logic       open_o
);

   localparam int unsigned WMAX = (WIN_ST > WIN_LD) ? WIN_ST : WIN_LD;
   localparam int unsigned CW   = $clog2(WMAX + 1);

   arm_e          kind_q;
   arm_e          cmd;
   logic [CW-1:0] win_q;

   assign cmd = decode_cmd(cmd_i);

   always_ff @(posedge clk) begin
      if ((!rst_n && !busy_i) || done_i) begin
         kind_q <= ARM_IDLE;
         win_q  <= '0;
      end else if (busy_i) begin
         kind_q <= kind_q;
      end else if (start_i) begin
         win_q  <= '0;
      end else if (take_i) begin
         kind_q <= ARM_IDLE;
         win_q  <= '0;
      end else if (wr_i) begin
         kind_q <= cmd;
         if (cmd == ARM_IDLE)       win_q <= '0;
         else if (cmd == ARM_CFGRD) win_q <= CW'(WIN_LD);
         else                       win_q <= CW'(WIN_ST);
      end else if (win_q == CW'(1)) begin
         kind_q <= ARM_IDLE;
         win_q  <= '0;
      end else if (win_q != '0) begin
         win_q  <= win_q - 1'b1;
      end
   end

   assign kind_o = kind_q;
   assign open_o = (win_q != '0);

endmodule

// File: rtl/fsp_optimer.sv
module fsp_optimer #(
   parameter int unsigned OP_CYCLES = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);

   localparam int unsigned TW = $clog2(OP_CYCLES + 1);

   logic [TW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk) begin
      if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end else if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= TW'(OP_CYCLES - 1);
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);

endmodule

// File: rtl/fsp_pagebuf.sv
module fsp_pagebuf #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned PAGE_WORDS = 4,
   localparam int unsigned OFF_W     = $clog2(PAGE_WORDS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         busy_i,
   input  logic                         clr_i,
   input  logic                         fill_i,
   input  logic [OFF_W-1:0]             off_i,
   input  logic [WORD_W-1:0]            data_i,
   output logic [PAGE_WORDS*WORD_W-1:0] flat_o
);

   for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if ((!rst_n && !busy_i) || clr_i)
            word_q <= '1;
         else if (fill_i && off_i == OFF_W'(w))
            word_q <= data_i;
      end
      assign flat_o[w*WORD_W +: WORD_W] = word_q;
   end

endmodule

// File: rtl/fsp_array.sv
module fsp_array #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned PAGE_WORDS = 4,
   parameter int unsigned PAGES      = 8,
   localparam int unsigned OFF_W     = $clog2(PAGE_WORDS),
   localparam int unsigned PG_W      = $clog2(PAGES),
   localparam int unsigned PTR_W     = OFF_W + PG_W
) (
   input  logic                         clk,
   input  logic                         start_i,
   input  logic                         erase_i,
   input  logic [PG_W-1:0]              page_i,
   input  logic                         done_i,
   input  logic [PAGE_WORDS*WORD_W-1:0] buf_i,
   input  logic [PTR_W-1:0]             rd_addr_i,
   output logic [WORD_W-1:0]            rd_o
);

   localparam int unsigned DEPTH = PAGES * PAGE_WORDS;

   logic [WORD_W-1:0] mem_q [DEPTH];
   logic [PG_W-1:0]   pg_q;
   logic              erase_q;

   always_ff @(posedge clk) begin
      if (start_i) begin
         pg_q    <= page_i;
         erase_q <= erase_i;
      end
      if (done_i) begin
         for (int w = 0; w < PAGE_WORDS; w++)
            mem_q[{pg_q, OFF_W'(w)}] <= erase_q ? '1 : buf_i[w*WORD_W +: WORD_W];
      end
   end

   assign rd_o = mem_q[rd_addr_i];

endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
   import fsp_pkg::*;
#(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned PAGE_WORDS = 4,
   parameter int unsigned PAGES      = 8,
   parameter int unsigned CLK_KHZ    = 1000,
   parameter int unsigned OP_US      = 4000,
   parameter int unsigned WIN_ST     = 4,
   parameter int unsigned WIN_LD     = 3,
   parameter logic [7:0]  FUSE_VAL   = 8'h62,
   parameter logic [7:0]  LOCK_VAL   = 8'hFC,
   localparam int unsigned OFF_W     = $clog2(PAGE_WORDS),
   localparam int unsigned PG_W      = $clog2(PAGES),
   localparam int unsigned PTR_W     = OFF_W + PG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              st_req,
   input  logic              ld_req,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [WORD_W-1:0] st_data,
   output logic              ld_valid,
   output logic [WORD_W-1:0] ld_data,
   output logic              busy
);

   localparam int unsigned OP_CYCLES = (CLK_KHZ * OP_US) / 1000;

   if (PAGE_WORDS < 2 || (PAGE_WORDS & (PAGE_WORDS - 1)) != 0) begin : g_bad_words
      $error("PAGE_WORDS must be a power of two of at least 2");
   end
   if (PAGES < 2 || (PAGES & (PAGES - 1)) != 0) begin : g_bad_pages
      $error("PAGES must be a power of two of at least 2");
   end
   if (WORD_W < 8) begin : g_bad_word
      $error("WORD_W must hold a configuration byte");
   end
   if (OP_US < 3700 || OP_US > 4500) begin : g_bad_time
      $error("OP_US must lie in the 3700..4500 band");
   end
   if (OP_CYCLES < 2) begin : g_bad_cycles
      $error("OP_CYCLES must be at least 2");
   end
   if (WIN_ST < 1 || WIN_LD < 1 || WIN_ST > 200 || WIN_LD > 200) begin : g_bad_win
      $error("arming windows must be 1..200 cycles");
   end

   arm_e              kind;
   logic              open, busy_w, done_w, live;
   logic              st_hit, cfg_hit, take, start, wr_ok, fill, buf_clr;
   logic [WORD_W-1:0] rd_word;
   logic [PAGE_WORDS*WORD_W-1:0] buf_flat;
   logic              unused_hi;

   assign unused_hi = ^reg_wdata[7:5];

   assign live    = rst_n && !busy_w;
   assign st_hit  = live && st_req && open &&
                    (kind == ARM_FILL || kind == ARM_ERASE || kind == ARM_WPROG);
   assign cfg_hit = live && ld_req && open && (kind == ARM_CFGRD);
   assign take    = st_hit || cfg_hit;
   assign start   = st_hit && (kind != ARM_FILL);
   assign fill    = st_hit && (kind == ARM_FILL);
   assign wr_ok   = live && reg_we && !take;
   assign buf_clr = (wr_ok && reg_wdata[CB_BUFCLR]) || (done_w && kind == ARM_WPROG);

   fsp_arm #(.WIN_ST(WIN_ST), .WIN_LD(WIN_LD)) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy_i  (busy_w),
      .done_i  (done_w),
      .wr_i    (wr_ok),
      .cmd_i   (reg_wdata[3:0]),
      .take_i  (take),
      .start_i (start),
      .kind_o  (kind),
      .open_o  (open)
   );

   fsp_optimer #(.OP_CYCLES(OP_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .busy_o  (busy_w),
      .done_o  (done_w)
   );

   fsp_pagebuf #(.WORD_W(WORD_W), .PAGE_WORDS(PAGE_WORDS)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (busy_w),
      .clr_i  (buf_clr),
      .fill_i (fill),
      .off_i  (ptr[OFF_W-1:0]),
      .data_i (st_data),
      .flat_o (buf_flat)
   );

   fsp_array #(.WORD_W(WORD_W), .PAGE_WORDS(PAGE_WORDS), .PAGES(PAGES)) u_mem (
      .clk       (clk),
      .start_i   (start),
      .erase_i   (kind == ARM_ERASE),
      .page_i    (ptr[PTR_W-1:OFF_W]),
      .done_i    (done_w),
      .buf_i     (buf_flat),
      .rd_addr_i (ptr),
      .rd_o      (rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_valid <= 1'b0;
         ld_data  <= '0;
      end else begin
         ld_valid <= live && ld_req;
         if (live && ld_req)
            ld_data <= cfg_hit ? WORD_W'(ptr[0] ? LOCK_VAL : FUSE_VAL) : rd_word;
      end
   end

   assign reg_rdata = {4'b0000,
                       kind == ARM_CFGRD,
                       kind == ARM_WPROG,
                       kind == ARM_ERASE,
                       kind != ARM_IDLE};
   assign busy = busy_w;

endmodule

// File: rtl/fsp_ctrl_chk.sv
module fsp_ctrl_chk #(
   parameter int unsigned WIN_ST = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_we,
   input logic [7:0] reg_rdata,
   input logic       st_req,
   input logic       ld_req,
   input logic       ld_valid,
   input logic       busy
);

   logic [7:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                     run_q <= '0;
      else if (reg_we)                run_q <= 8'd1;
      else if (reg_rdata[0] && !busy) run_q <= run_q + 1'b1;
      else                            run_q <= '0;
   end

   p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[7:4] == 4'b0000);

   p_busy_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> reg_rdata[0] && !reg_rdata[3] && $countones(reg_rdata[3:1]) == 1);

   p_busy_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(st_req));

   p_window_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[0] && !busy) |-> run_q <= 8'(WIN_ST));

   p_quiet_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !ld_valid);

   p_hold_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we) |=> (!busy || $stable(reg_rdata)));

   p_valid_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> $past(ld_req));

endmodule

bind fsp_ctrl fsp_ctrl_chk #(.WIN_ST(WIN_ST)) u_chk (.*);

// File: tb/fsp_ctrl_tb_top.sv
module fsp_ctrl_tb_top;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned WORD_W     = 16;
   localparam int unsigned PAGE_WORDS = 4;
   localparam int unsigned PAGES      = 8;
   localparam int unsigned CLK_KHZ    = 1000;
   localparam int unsigned OP_US      = 4000;
   localparam logic [7:0]  FUSE_VAL   = 8'h62;
   localparam logic [7:0]  LOCK_VAL   = 8'hFC;
   localparam int unsigned OFF_W      = $clog2(PAGE_WORDS);
   localparam int unsigned PTR_W      = OFF_W + $clog2(PAGES);
   localparam int unsigned OP_CYCLES  = (CLK_KHZ * OP_US) / 1000;
   localparam int unsigned DEPTH      = PAGES * PAGE_WORDS;
   localparam logic [WORD_W-1:0] ONES = '1;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              reg_we;
   logic [7:0]        reg_wdata;
   logic [7:0]        reg_rdata;
   logic              st_req, ld_req;
   logic [PTR_W-1:0]  ptr;
   logic [WORD_W-1:0] st_data;
   logic              ld_valid;
   logic [WORD_W-1:0] ld_data;
   logic              busy;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [WORD_W-1:0] exp_mem [DEPTH];
   bit                exp_known [DEPTH];
   logic [WORD_W-1:0] exp_buf [PAGE_WORDS];

   always #(CLK_PERIOD/2) clk = ~clk;

   fsp_ctrl #(
      .WORD_W(WORD_W), .PAGE_WORDS(PAGE_WORDS), .PAGES(PAGES),
      .CLK_KHZ(CLK_KHZ), .OP_US(OP_US), .WIN_ST(4), .WIN_LD(3),
      .FUSE_VAL(FUSE_VAL), .LOCK_VAL(LOCK_VAL)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .st_req(st_req), .ld_req(ld_req), .ptr(ptr),
      .st_data(st_data), .ld_valid(ld_valid), .ld_data(ld_data), .busy(busy)
   );

   function automatic logic [WORD_W-1:0] exp_cfg(input int p);
      return WORD_W'((p % 2 == 1) ? LOCK_VAL : FUSE_VAL);
   endfunction

   function automatic logic [PTR_W-1:0] mk_ptr(input int pg, input int off);
      return PTR_W'(pg * PAGE_WORDS + off);
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [7:0] v);
      reg_we = 1'b1; reg_wdata = v;
      tick();
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic store(input logic [PTR_W-1:0] p, input logic [WORD_W-1:0] d);
      st_req = 1'b1; ptr = p; st_data = d;
      tick();
      st_req = 1'b0;
   endtask

   task automatic load(input logic [PTR_W-1:0] p, output logic v, output logic [WORD_W-1:0] d);
      ld_req = 1'b1; ptr = p;
      tick();
      ld_req = 1'b0;
      v = ld_valid; d = ld_data;
   endtask

   task automatic buf_clear_model();
      for (int w = 0; w < PAGE_WORDS; w++) exp_buf[w] = ONES;
   endtask

   task automatic fill_word(input int off, input logic [WORD_W-1:0] d);
      wr_reg(8'h01);
      store(mk_ptr(0, off), d);
      exp_buf[off] = d;
   endtask

   task automatic commit_model(input bit erase, input int pg);
      for (int w = 0; w < PAGE_WORDS; w++) begin
         exp_mem[pg*PAGE_WORDS + w]   = erase ? ONES : exp_buf[w];
         exp_known[pg*PAGE_WORDS + w] = 1'b1;
      end
      if (!erase) buf_clear_model();
   endtask

   // waits out an operation started used_ticks ticks ago (ticks counted after the start edge)
   task automatic finish_op(input string rq, input int used_ticks);
      repeat (OP_CYCLES - 1 - used_ticks) tick();
      chk({rq, " busy on last cycle"}, busy, 1);
      tick();
      chk({rq, " busy falls"}, busy, 0);
      chk({rq, " readback after op"}, reg_rdata, 8'h00);
   endtask

   task automatic page_op(input bit erase, input int pg);
      logic [7:0] cmd;
      cmd = erase ? 8'h03 : 8'h05;
      wr_reg(cmd);
      store(mk_ptr(pg, 0), '0);
      chk("R8 busy rises", busy, 1);
      chk("R8 readback while busy", reg_rdata, cmd);
      finish_op("R8", 0);
      commit_model(erase, pg);
   endtask

   task automatic check_page(input string rq, input int pg);
      logic v; logic [WORD_W-1:0] d;
      for (int w = 0; w < PAGE_WORDS; w++) begin
         load(mk_ptr(pg, w), v, d);
         chk({rq, " R11 load valid"}, v, 1);
         chk({rq, " page word"}, d, exp_mem[pg*PAGE_WORDS + w]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic v;
      logic [WORD_W-1:0] d;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0; st_req = 1'b0; ld_req = 1'b0;
      ptr = '0; st_data = '0;
      for (int i = 0; i < DEPTH; i++) begin exp_mem[i] = '0; exp_known[i] = 1'b0; end
      buf_clear_model();

      @(negedge clk);
      repeat (3) tick();
      chk("R1 readback in reset", reg_rdata, 8'h00);
      chk("R1 busy in reset", busy, 0);
      chk("R1 ld_valid in reset", ld_valid, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 readback after reset", reg_rdata, 8'h00);

      // R2/R3: all bits written, erase wins, upper bits read zero, window expiry R4
      wr_reg(8'hFF);
      chk("R2 R3 all-ones write reads erase+enable", reg_rdata, 8'h03);
      buf_clear_model();
      repeat (3) tick();
      chk("R4 still armed on last window cycle", reg_rdata, 8'h03);
      tick();
      chk("R4 armed bits expire", reg_rdata, 8'h00);

      // R3: no enable arms nothing; write beats configuration read
      wr_reg(8'h0C);
      chk("R3 no enable arms nothing", reg_rdata, 8'h00);
      wr_reg(8'h0D);
      chk("R3 write beats cfg read", reg_rdata, 8'h05);
      repeat (4) tick();
      chk("R4 write arm expires", reg_rdata, 8'h00);

      // R10: configuration reads, including last edge of window
      wr_reg(8'h09);
      chk("R3 cfg read armed", reg_rdata, 8'h09);
      load(mk_ptr(0, 0), v, d);
      chk("R10 fuse valid", v, 1);
      chk("R10 fuse value", d, exp_cfg(0));
      chk("R10 armed bits cleared", reg_rdata, 8'h00);
      wr_reg(8'h09); tick();
      load(mk_ptr(0, 1), v, d);
      chk("R10 lock value", d, exp_cfg(1));
      wr_reg(8'h09); tick(); tick();
      load(mk_ptr(0, 1), v, d);
      chk("R10 R4 lock on last window edge", d, exp_cfg(1));

      // R7 erase page 0
      page_op(1'b1, 0);
      check_page("R7 erase page0", 0);

      // R4 late configuration load returns the program word
      wr_reg(8'h09); repeat (3) tick();
      chk("R4 cfg window expired", reg_rdata, 8'h00);
      load(mk_ptr(0, 1), v, d);
      chk("R4 R11 late load gives array word", d, ONES);

      // R4 late store starts nothing
      wr_reg(8'h05); repeat (4) tick();
      store(mk_ptr(0, 0), '0);
      chk("R4 late store no busy", busy, 0);

      // R5 fill: last window edge accepted, late fill ignored
      wr_reg(8'h01); repeat (3) tick();
      store(mk_ptr(0, 2), 16'hA5A5);
      exp_buf[2] = 16'hA5A5;
      chk("R5 enable cleared after fill", reg_rdata, 8'h00);
      wr_reg(8'h01); repeat (4) tick();
      store(mk_ptr(0, 1), 16'hBEEF);
      fill_word(0, 16'h1234);
      page_op(1'b0, 1);
      check_page("R5 R4 fill page1", 1);
      page_op(1'b0, 1);
      check_page("R7 buffer back to ones page1", 1);

      // R6 clear discards loaded words
      fill_word(0, 16'h1111); fill_word(1, 16'h2222);
      wr_reg(8'h10);
      buf_clear_model();
      chk("R6 R2 clear bit reads zero", reg_rdata, 8'h00);
      fill_word(3, 16'h4D4D);
      page_op(1'b0, 2);
      check_page("R6 clear page2", 2);

      // R9 everything ignored while busy
      fill_word(0, 16'hE0E0);
      wr_reg(8'h05);
      store(mk_ptr(3, 0), '0);
      wr_reg(8'h09);
      chk("R9 reg write ignored while busy", reg_rdata, 8'h05);
      store(mk_ptr(3, 1), 16'hF0F0);
      load(mk_ptr(0, 0), v, d);
      chk("R9 load ignored while busy", v, 0);
      finish_op("R9", 3);
      commit_model(1'b0, 3);
      check_page("R9 page3", 3);

      // R12 reset during a running write
      fill_word(2, 16'h6C6C);
      wr_reg(8'h05);
      store(mk_ptr(4, 0), '0);
      repeat (5) tick();
      rst_n = 1'b0;
      repeat (10) tick();
      chk("R12 busy held through reset", busy, 1);
      rst_n = 1'b1;
      finish_op("R12", 15);
      commit_model(1'b0, 4);
      check_page("R12 page4", 4);

      // R13 accepted fill and a clearing register write on the same edge
      wr_reg(8'h01);
      reg_we = 1'b1; reg_wdata = 8'h10;
      st_req = 1'b1; ptr = mk_ptr(0, 1); st_data = 16'h7E7E;
      tick();
      reg_we = 1'b0; reg_wdata = '0; st_req = 1'b0;
      exp_buf[1] = 16'h7E7E;
      chk("R13 register write dropped", reg_rdata, 8'h00);
      page_op(1'b0, 5);
      check_page("R13 store kept page5", 5);

      // constrained random fills, clears and page writes
      for (int it = 0; it < 6; it++) begin
         int pg;
         int nf;
         pg = int'($urandom % PAGES);
         nf = 1 + int'($urandom % 6);
         for (int k = 0; k < nf; k++)
            fill_word(int'($urandom % PAGE_WORDS), WORD_W'($urandom));
         if ($urandom % 3 == 0) begin
            wr_reg(8'h10);
            buf_clear_model();
            fill_word(int'($urandom % PAGE_WORDS), WORD_W'($urandom));
         end
         page_op(1'b0, pg);
         for (int k = 0; k < 3; k++) begin
            int w;
            w = int'($urandom % PAGE_WORDS);
            load(mk_ptr(pg, w), v, d);
            chk("R7 R11 random readback", d, exp_mem[pg*PAGE_WORDS + w]);
         end
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule